// File: doc/BRIEF.md
# Bulk Erase Sequencer

This block runs the full closed-loop bulk erase of an electrically erasable memory that is driven through a command interface. A host pulses `start`. The sequencer raises the high-voltage enable and sends the two-write erase command, each write carrying code 20h. It then waits out the erase pulse and checks the array one byte at a time. For each byte it writes the verify command A0h at the byte's address, waits a short settling time, and reads the byte back. A byte that reads FFh is blank, and the walk moves on to the next address. A byte that reads anything else triggers another erase pulse. Checking then picks up again at that failing address, not at address zero.

The memory's bus signalling belongs to a separate bus driver. The sequencer sends it one request at a time (write or read, address, write data). It holds each request until the driver answers with `req_ack`, and on a read the returned byte comes back with that acknowledge. All wait durations are parameters counted in clock cycles. The erase pulse is nominally 100 ms and the verify settling time about 6 us.

A run ends in one of two ways. On success the sequencer writes 00h to put the memory back in read mode, drops the high voltage and pulses `done`. If a byte still fails after the maximum number of erase pulses, it drops the high voltage and pulses `error`. The number of pulses used stays visible on `pulse_count`.

States: IDLE (waiting for start), SETUP (first 20h write), ERASE (second 20h write, which counts one pulse), PULSE (erase-time wait), VCMD (A0h write at the verify address), VWAIT (settling wait), VREAD (read-back), RDMODE (00h write), DONE (one-cycle done), FAIL (one-cycle error).

Transitions:
- IDLE→SETUP on start.
- SETUP→ERASE on ack.
- ERASE→PULSE on ack.
- PULSE→VCMD when the timer expires.
- VCMD→VWAIT on ack.
- VWAIT→VREAD when the timer expires.
- VREAD→VCMD on a blank byte that is not the last.
- VREAD→RDMODE on a blank last byte.
- VREAD→SETUP on a non-blank byte below the pulse limit.
- VREAD→FAIL on a non-blank byte at the limit.
- RDMODE→DONE on ack.
- DONE→IDLE and FAIL→IDLE unconditionally.

Top module: `erase_seq`

## Requirements
- R1: Out of reset and while idle, `hv_en`, `done`, `error` and `req_valid` are 0, and `pulse_count` is 0 after reset. No bus request is ever issued while `hv_en` is 0.
- R2: On `start` in idle, `hv_en` rises and `pulse_count` clears. The first two bus requests are writes of 20h, and every erase pulse is started by such a pair, with no other write between the two.
- R3: After the acknowledge of the second 20h write, no request is raised for at least PULSE_CYC cycles. The next request is a write of A0h carrying the current verify address.
- R4: After the acknowledge of an A0h write, no request is raised for at least VFY_WAIT_CYC cycles. The next request is a read at the same address as that A0h write.
- R5: A read returning FFh at an address other than LAST_ADDR is followed directly by an A0h write at address + 1, with no erase in between.
- R6: A read returning a value other than FFh, while fewer than MAX_PULSES pulses have been applied, is followed directly by a new 20h/20h pair. Verification then resumes at the failing address.
- R7: A read returning FFh at LAST_ADDR is followed by a write of 00h. After that write's acknowledge, `done` pulses for exactly one cycle with `hv_en` already 0.
- R8: A read returning a value other than FFh after MAX_PULSES pulses ends the run. `error` pulses for exactly one cycle with `hv_en` 0, no 00h write is issued, and `pulse_count` equals MAX_PULSES.
- R9: `pulse_count` equals the number of erase pulses applied in the current or most recent run, never exceeds MAX_PULSES, and holds its value after the run ends.
- R10: `start` is ignored while a run is in progress. The run's bus traffic, pulse count and single completion pulse are unchanged.
- R11: While `req_valid` is 1 and `req_ack` is 0, the request's direction, address and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an erase run (taken only in idle) |
| done | output | 1 | One-cycle pulse: array verified blank |
| error | output | 1 | One-cycle pulse: pulse limit reached with a failing byte |
| hv_en | output | 1 | Program/erase high-voltage enable |
| req_valid | output | 1 | Bus cycle requested; held until acknowledged |
| req_write | output | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | output | ADDR_W | Bus cycle address |
| req_wdata | output | 8 | Command byte for write cycles |
| req_ack | input | 1 | Bus cycle completed (one cycle) |
| req_rdata | input | 8 | Byte read, valid with req_ack on a read |
| pulse_count | output | $clog2(MAX_PULSES+1) | Erase pulses applied in this or the last run |

## Verification
A wrong verify address shows up within one bus cycle: the read no longer matches the address of the preceding A0h write, or the total number of verify reads for a given pattern of slow-to-erase bytes changes. A restart at zero instead of a resume makes that total grow by the number of bytes already checked. A miscounted pulse appears at the end of the run, as a wrong `pulse_count` or the wrong outcome at the pulse limit. A wait state that is cut short shows up in the idle gap measured after the erase or verify command. A wrong exit from DONE or FAIL shows up the next cycle, as a completion pulse that is too wide or has the high voltage still on.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ERASE,
        ST_PULSE,
        ST_VCMD,
        ST_VWAIT,
        ST_VREAD,
        ST_RDMODE,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/erase_seq_tracker.sv
module erase_seq_tracker #(
    parameter int                ADDR_W     = 17,
    parameter logic [ADDR_W-1:0] LAST_ADDR  = '1,
    parameter int                MAX_PULSES = 30,
    parameter int                PC_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              addr_inc,
    input  logic              pulse_inc,
    output logic [ADDR_W-1:0] addr,
    output logic [PC_W-1:0]   pulses,
    output logic              at_last,
    output logic              at_limit
);

    localparam logic [PC_W-1:0] LIMIT = PC_W'(MAX_PULSES);

    logic [ADDR_W-1:0] addr_q;
    logic [PC_W-1:0]   pulses_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear) begin
            addr_q <= '0;
        end else if (addr_inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses_q <= '0;
        end else if (clear) begin
            pulses_q <= '0;
        end else if (pulse_inc) begin
            pulses_q <= pulses_q + 1'b1;
        end
    end

    assign addr     = addr_q;
    assign pulses   = pulses_q;
    assign at_last  = (addr_q == LAST_ADDR);
    assign at_limit = (pulses_q == LIMIT);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int                ADDR_W       = 17,
    parameter logic [ADDR_W-1:0] LAST_ADDR    = '1,
    parameter int                MAX_PULSES   = 30,
    parameter int                PULSE_CYC    = 10_000_000,
    parameter int                VFY_WAIT_CYC = 600,
    localparam int               PC_W         = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              error,
    output logic              hv_en,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic              req_ack,
    input  logic [7:0]        req_rdata,
    output logic [PC_W-1:0]   pulse_count
);

    localparam int TMAX = (PULSE_CYC > VFY_WAIT_CYC) ? PULSE_CYC : VFY_WAIT_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t        state_q, state_d;
    logic              t_load, t_expired;
    logic [TW-1:0]     t_val;
    logic              trk_clear, trk_addr_inc, trk_pulse_inc;
    logic [ADDR_W-1:0] vaddr;
    logic              at_last, at_limit;

    erase_seq_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    erase_seq_tracker #(
        .ADDR_W     (ADDR_W),
        .LAST_ADDR  (LAST_ADDR),
        .MAX_PULSES (MAX_PULSES),
        .PC_W       (PC_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (trk_clear),
        .addr_inc  (trk_addr_inc),
        .pulse_inc (trk_pulse_inc),
        .addr      (vaddr),
        .pulses    (pulse_count),
        .at_last   (at_last),
        .at_limit  (at_limit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and sequencing strobes
    always_comb begin
        state_d       = state_q;
        t_load        = 1'b0;
        t_val         = '0;
        trk_clear     = 1'b0;
        trk_addr_inc  = 1'b0;
        trk_pulse_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    trk_clear = 1'b1;
                    state_d   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (req_ack) state_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (req_ack) begin
                    trk_pulse_inc = 1'b1;
                    t_load        = 1'b1;
                    t_val         = TW'(PULSE_CYC);
                    state_d       = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (t_expired) state_d = ST_VCMD;
            end
            ST_VCMD: begin
                if (req_ack) begin
                    t_load  = 1'b1;
                    t_val   = TW'(VFY_WAIT_CYC);
                    state_d = ST_VWAIT;
                end
            end
            ST_VWAIT: begin
                if (t_expired) state_d = ST_VREAD;
            end
            ST_VREAD: begin
                if (req_ack) begin
                    if (req_rdata == BYTE_BLANK) begin
                        if (at_last) begin
                            state_d = ST_RDMODE;
                        end else begin
                            trk_addr_inc = 1'b1;
                            state_d      = ST_VCMD;
                        end
                    end else if (at_limit) begin
                        state_d = ST_FAIL;
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_RDMODE: begin
                if (req_ack) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        hv_en     = 1'b1;
        done      = 1'b0;
        error     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b1;
        req_addr  = '0;
        req_wdata = CMD_READ;
        unique case (state_q)
            ST_IDLE:  hv_en = 1'b0;
            ST_SETUP, ST_ERASE: begin
                req_valid = 1'b1;
                req_wdata = CMD_ERASE;
            end
            ST_PULSE, ST_VWAIT: ;
            ST_VCMD: begin
                req_valid = 1'b1;
                req_addr  = vaddr;
                req_wdata = CMD_VERIFY;
            end
            ST_VREAD: begin
                req_valid = 1'b1;
                req_write = 1'b0;
                req_addr  = vaddr;
            end
            ST_RDMODE: begin
                req_valid = 1'b1;
                req_wdata = CMD_READ;
            end
            ST_DONE: begin
                hv_en = 1'b0;
                done  = 1'b1;
            end
            ST_FAIL: begin
                hv_en = 1'b0;
                error = 1'b1;
            end
            default: hv_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
    parameter int                ADDR_W     = 17,
    parameter logic [ADDR_W-1:0] LAST_ADDR  = '1,
    parameter int                MAX_PULSES = 30,
    parameter int                PC_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              error,
    input logic              hv_en,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_wdata,
    input logic              req_ack,
    input logic [7:0]        req_rdata,
    input logic [PC_W-1:0]   pulse_count
);

    // R1
    no_bus_without_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> hv_en);

    // R2
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> (pulse_count == '0));

    // R5
    next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ack && req_rdata == 8'hFF && req_addr != LAST_ADDR)
        |=> (req_valid && req_write && req_wdata == 8'hA0 && req_addr == $past(req_addr) + 1'b1));

    // R6
    re_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ack && req_rdata != 8'hFF && pulse_count < PC_W'(MAX_PULSES))
        |=> (req_valid && req_write && req_wdata == 8'h20));

    // R7
    done_hv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !hv_en);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    error_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    // R8
    error_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (pulse_count == PC_W'(MAX_PULSES) && !hv_en && !done));

    // R9
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_count <= PC_W'(MAX_PULSES));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_write)
                                     && $stable(req_addr) && $stable(req_wdata)));

endmodule

bind erase_seq erase_seq_chk #(
    .ADDR_W     (ADDR_W),
    .LAST_ADDR  (LAST_ADDR),
    .MAX_PULSES (MAX_PULSES),
    .PC_W       (PC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .error       (error),
    .hv_en       (hv_en),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ack     (req_ack),
    .req_rdata   (req_rdata),
    .pulse_count (pulse_count)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;

    localparam int             AW    = 4;
    localparam logic [AW-1:0]  LASTA = 4'd15;
    localparam int             MAXP  = 30;
    localparam int             PCYC  = 20;
    localparam int             VCYC  = 5;
    localparam int             PCW   = $clog2(MAXP + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           done, error, hv_en;
    logic           req_valid, req_write;
    logic [AW-1:0]  req_addr;
    logic [7:0]     req_wdata;
    logic           req_ack = 1'b0;
    logic [7:0]     req_rdata = 8'h00;
    logic [PCW-1:0] pulse_count;

    always #2 clk = ~clk;

    erase_seq #(
        .ADDR_W(AW), .LAST_ADDR(LASTA), .MAX_PULSES(MAXP),
        .PULSE_CYC(PCYC), .VFY_WAIT_CYC(VCYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
        .hv_en(hv_en), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .pulse_count(pulse_count)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model: byte a becomes blank after need(scn, a) erase pulses.
    int scn = 0;
    function automatic int need(input int s, input int a);
        case (s)
            1: return (a == 5) ? 3 : 1;
            2: return (a == 15) ? 2 : 1;
            3: return (a == 3) ? 31 : 1;
            4: return (a == 2) ? 2 : ((a == 9) ? 4 : 1);
            5: return (a == 0) ? 30 : 1;
            default: return 1;
        endcase
    endfunction

    int erase_cnt, reads, done_cnt, err_cnt, wide_cnt, hv_bad, lastw_bad;
    int orphan, a0_bad, zero_writes, hold_bad, min_pgap, min_vgap, gap, gap_kind;
    int last_a0;
    bit pair_open, resp_wait, prev_done, prev_err;
    logic [7:0]    last_wdata, cap_wdata;
    logic [AW-1:0] cap_addr;
    logic          cap_write;

    task automatic clear_model();
        erase_cnt = 0; reads = 0; done_cnt = 0; err_cnt = 0; wide_cnt = 0;
        hv_bad = 0; lastw_bad = 0; orphan = 0; a0_bad = 0; zero_writes = 0;
        hold_bad = 0; min_pgap = 1_000_000; min_vgap = 1_000_000; gap = 0;
        gap_kind = 0; last_a0 = -1; pair_open = 0; last_wdata = 8'h55;
    endtask

    // Bus responder and monitor: acts one negedge after a request appears.
    initial begin
        clear_model();
        resp_wait = 0; prev_done = 0; prev_err = 0;
        forever begin
            @(negedge clk);
            if (done) begin
                done_cnt++;
                if (hv_en) hv_bad++;
                if (last_wdata != 8'h00) lastw_bad++;
            end
            if (error) begin
                err_cnt++;
                if (hv_en) hv_bad++;
            end
            if ((done && prev_done) || (error && prev_err)) wide_cnt++;
            prev_done = done;
            prev_err  = error;
            if (req_ack) begin
                req_ack = 1'b0;
            end else if (resp_wait) begin
                resp_wait = 0;
                if (!req_valid || req_write != cap_write || req_addr != cap_addr
                    || req_wdata != cap_wdata) hold_bad++;
                gap_kind = 0;
                if (req_write) begin
                    if (req_wdata == 8'h20) begin
                        if (pair_open) begin
                            erase_cnt++;
                            pair_open = 0;
                            gap_kind  = 1;
                        end else begin
                            pair_open = 1;
                        end
                    end else begin
                        if (pair_open) orphan++;
                        pair_open = 0;
                        if (req_wdata == 8'hA0) begin
                            last_a0  = int'(req_addr);
                            gap_kind = 2;
                        end
                        if (req_wdata == 8'h00) zero_writes++;
                    end
                    last_wdata = req_wdata;
                end else begin
                    reads++;
                    if (int'(req_addr) != last_a0) a0_bad++;
                    req_rdata = (erase_cnt >= need(scn, int'(req_addr))) ? 8'hFF : 8'h7E;
                end
                req_ack = 1'b1;
                gap = 0;
            end else if (req_valid) begin
                if (gap_kind == 1 && gap < min_pgap) min_pgap = gap;
                if (gap_kind == 2 && gap < min_vgap) min_vgap = gap;
                gap_kind  = 0;
                cap_write = req_write;
                cap_addr  = req_addr;
                cap_wdata = req_wdata;
                resp_wait = 1;
            end else begin
                gap++;
            end
        end
    end

    task automatic run_scn(input int s, input int exp_p, input bit exp_err,
                           input int exp_reads, input bit extra_start);
        int n;
        clear_model();
        scn = s;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(pulse_count == '0, "R2/R9 pulse_count cleared at start", int'(pulse_count), 0);
        check(hv_en == 1'b1, "R2 hv_en raised after start", int'(hv_en), 1);
        n = 0;
        while (done_cnt + err_cnt == 0 && n < 20000) begin
            @(negedge clk);
            n++;
            if (extra_start && (n == 40 || n == 200)) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(done_cnt + err_cnt == 1, $sformatf("R10 single completion scn %0d", s), done_cnt + err_cnt, 1);
        if (exp_err) begin
            check(err_cnt == 1, $sformatf("R8 error outcome scn %0d", s), err_cnt, 1);
            check(zero_writes == 0, "R8 no read-mode write on error", zero_writes, 0);
        end else begin
            check(done_cnt == 1, $sformatf("R7 done outcome scn %0d", s), done_cnt, 1);
            check(lastw_bad == 0, "R7 last write before done is 00h", lastw_bad, 0);
        end
        check(int'(pulse_count) == exp_p, $sformatf("R9 pulse_count scn %0d", s), int'(pulse_count), exp_p);
        check(erase_cnt == exp_p, $sformatf("R2 erase pairs scn %0d", s), erase_cnt, exp_p);
        check(reads == exp_reads, $sformatf("R5/R6 verify reads scn %0d", s), reads, exp_reads);
        check(orphan == 0, "R2 setup write not followed by erase write", orphan, 0);
        check(min_pgap >= PCYC, "R3 erase pulse wait", min_pgap, PCYC);
        check(min_vgap >= VCYC, "R4 verify settling wait", min_vgap, VCYC);
        check(a0_bad == 0, "R4 read address matches verify command", a0_bad, 0);
        check(hold_bad == 0, "R11 request held until ack", hold_bad, 0);
        check(wide_cnt == 0 && hv_bad == 0, "R7/R8 completion pulse width and hv_en", wide_cnt + hv_bad, 0);
        check(!hv_en && !req_valid, "R1 idle after run", int'(hv_en) + int'(req_valid), 0);
    endtask

    // {scenario, expected pulses, expected error, expected verify reads}
    localparam logic [31:0] VEC [6] = '{
        {8'd0, 8'd1,  8'd0, 8'd16},
        {8'd1, 8'd3,  8'd0, 8'd18},
        {8'd2, 8'd2,  8'd0, 8'd17},
        {8'd3, 8'd30, 8'd1, 8'd33},
        {8'd4, 8'd4,  8'd0, 8'd19},
        {8'd5, 8'd30, 8'd0, 8'd45}
    };

    initial begin
        repeat (3) @(negedge clk);
        check(!hv_en && !done && !error && !req_valid, "R1 outputs in reset",
              int'(hv_en) + int'(done) + int'(error) + int'(req_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!hv_en && !done && !error && !req_valid && pulse_count == '0,
              "R1 idle after reset", int'(hv_en) + int'(req_valid) + int'(pulse_count), 0);

        for (int i = 0; i < 6; i++) begin
            run_scn(int'(VEC[i][31:24]), int'(VEC[i][23:16]), VEC[i][8],
                    int'(VEC[i][7:0]), 1'b0);
        end

        // R10: start pulses in mid-run must not disturb the run
        run_scn(1, 3, 1'b0, 18, 1'b1);

        // R9: count holds after the run ends
        repeat (10) @(negedge clk);
        check(pulse_count == PCW'(3), "R9 pulse_count held in idle", int'(pulse_count), 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired R1 actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule